// File: doc/BRIEF.md
# Two-Channel Program Address Breakpoint Unit

This block watches a processor's instruction-fetch stream and raises a break interrupt when a fetch lands on an address that software has programmed into either of its two channels, A or B. Each channel holds a 24-bit target address, a 24-bit mask that removes bit positions from the compare, and an enable bit. When a channel hits, it sets a sticky hit flag. Both flags feed one shared interrupt line. The handler reads the flags to tell which channel fired.

A flag can be cleared only by a deliberate sequence. Software must first read the flag while it is 1, then write 0 to it. Fetches that the processor marks as discarded never cause a hit. These are the slots that follow a taken branch, call, trap or return. While another bus master owns the bus, the interrupt request is held back, and it is delivered once the processor owns the bus again.

The block comes out of reset halted. It is started by clearing a stop bit through the byte-wide register port.

Top module: `pc_break_unit`

## Requirements
- R1: After reset the stop bit (address 0xF, bit 0) reads 1, both hit flags and enables read 0, all address and mask bytes read 0, and `brk_irq` is 0.
- R2: While the stop bit is 1, writes to any register other than 0xF are ignored, reads of those registers return 0, and fetches never set a hit flag.
- R3: A channel sets its hit flag on the clock edge that samples a valid, non-discarded fetch whose address equals the channel address in every bit where the mask is 0. Mask bits set to 1 are excluded from the compare. Address bytes (low to high) are at 0x0–0x2 for A and 0x8–0xA for B. Mask bytes are at 0x4–0x6 for A and 0xC–0xE for B.
- R4: A channel with its enable bit at 0 never sets its flag. The enable is bit 0 of the control byte, at 0x3 for A and 0xB for B.
- R5: A fetch presented with `if_discard` at 1 sets no flag, even when its address matches.
- R6: A hit flag (bit 1 of the channel control byte) stays at 1 until software clears it. Writing 1 to it never sets it.
- R7: A write of 0 to a flag clears it only if that flag was read as 1 since the last write to the same control byte. Any write to the control byte discards that earlier read.
- R8: `brk_irq` is 1 whenever either flag is 1, the block is running and `bus_cpu` is 1. A hit on both channels by one fetch sets both flags in the same cycle.
- R9: While `bus_cpu` is 0, `brk_irq` stays 0 even with a flag set. It asserts once `bus_cpu` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Instruction fetch strobe |
| if_addr | input | 24 | Fetch address |
| if_discard | input | 1 | Fetch will be discarded (slot after a branch) |
| bus_cpu | input | 1 | Processor currently owns the bus |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered one cycle after `reg_rd` |
| brk_irq | output | 1 | Shared break interrupt request |

## Verification
The compare is tried with an exact-address hit under a partial mask, with a near miss that differs only in an unmasked bit, and with a hit on a channel that is disabled. Together these separate a correct masked compare from one that ignores the mask or the enable. The same matching address is also presented as a discarded fetch, while the block is stopped, and on both channels at once, which shows that the qualifiers act and that the two flags set independently. The clear sequence is tried in three forms: a zero write without a prior read, a read followed by a zero write, and a read followed by another write and then a zero write. The interrupt is watched with the bus held by another master and again after the bus is handed back.

// File: rtl/pc_break_unit.sv
module pc_break_unit #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_valid,
  input  logic [AW-1:0] if_addr,
  input  logic          if_discard,
  input  logic          bus_cpu,
  input  logic [3:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_rd,
  output logic [7:0]    reg_rdata,
  output logic          brk_irq
);

  logic          stop;
  logic [AW-1:0] tgt_a, tgt_b, msk_a, msk_b;
  logic          en_a, en_b, flag_a, flag_b, seen_a, seen_b;

  wire run   = ~stop;
  wire fetch = run & if_valid & ~if_discard;
  wire hit_a = fetch & en_a & (((if_addr ^ tgt_a) & ~msk_a) == '0);
  wire hit_b = fetch & en_b & (((if_addr ^ tgt_b) & ~msk_b) == '0);

  wire wr_run  = reg_wr & run;
  wire wr_ca   = wr_run & (reg_addr == 4'h3);
  wire wr_cb   = wr_run & (reg_addr == 4'hB);
  wire clr_a   = wr_ca & ~reg_wdata[1] & seen_a;
  wire clr_b   = wr_cb & ~reg_wdata[1] & seen_b;
  wire rd_ca   = reg_rd & run & (reg_addr == 4'h3);
  wire rd_cb   = reg_rd & run & (reg_addr == 4'hB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop <= 1'b1;
      tgt_a <= '0; tgt_b <= '0; msk_a <= '0; msk_b <= '0;
      en_a <= 1'b0; en_b <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 4'hF) stop <= reg_wdata[0];
      if (wr_run) begin
        case (reg_addr)
          4'h0: tgt_a[7:0]   <= reg_wdata;
          4'h1: tgt_a[15:8]  <= reg_wdata;
          4'h2: tgt_a[23:16] <= reg_wdata;
          4'h3: en_a         <= reg_wdata[0];
          4'h4: msk_a[7:0]   <= reg_wdata;
          4'h5: msk_a[15:8]  <= reg_wdata;
          4'h6: msk_a[23:16] <= reg_wdata;
          4'h8: tgt_b[7:0]   <= reg_wdata;
          4'h9: tgt_b[15:8]  <= reg_wdata;
          4'hA: tgt_b[23:16] <= reg_wdata;
          4'hB: en_b         <= reg_wdata[0];
          4'hC: msk_b[7:0]   <= reg_wdata;
          4'hD: msk_b[15:8]  <= reg_wdata;
          4'hE: msk_b[23:16] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a <= 1'b0; flag_b <= 1'b0;
      seen_a <= 1'b0; seen_b <= 1'b0;
    end else begin
      flag_a <= hit_a | (flag_a & ~clr_a);
      flag_b <= hit_b | (flag_b & ~clr_b);
      if (wr_ca)                seen_a <= 1'b0;
      else if (rd_ca && flag_a) seen_a <= 1'b1;
      if (wr_cb)                seen_b <= 1'b0;
      else if (rd_cb && flag_b) seen_b <= 1'b1;
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = 8'h00;
    if (reg_addr == 4'hF) rd_mux = {7'd0, stop};
    else if (run) begin
      case (reg_addr)
        4'h0: rd_mux = tgt_a[7:0];
        4'h1: rd_mux = tgt_a[15:8];
        4'h2: rd_mux = tgt_a[23:16];
        4'h3: rd_mux = {6'd0, flag_a, en_a};
        4'h4: rd_mux = msk_a[7:0];
        4'h5: rd_mux = msk_a[15:8];
        4'h6: rd_mux = msk_a[23:16];
        4'h8: rd_mux = tgt_b[7:0];
        4'h9: rd_mux = tgt_b[15:8];
        4'hA: rd_mux = tgt_b[23:16];
        4'hB: rd_mux = {6'd0, flag_b, en_b};
        4'hC: rd_mux = msk_b[7:0];
        4'hD: rd_mux = msk_b[15:8];
        4'hE: rd_mux = msk_b[23:16];
        default: rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= 8'h00;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign brk_irq = (flag_a | flag_b) & run & bus_cpu;

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !(reg_wr && reg_addr == 4'h3 && !reg_wdata[1])) |=> flag_a);

  // R7
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_b) |-> $past(seen_b));

  // R2
  stopped_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ($stable(flag_a) && $stable(flag_b) && $stable(tgt_a) && $stable(msk_b)
              && $stable(en_a) && $stable(en_b)));

  // R5
  discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_valid && if_discard && !flag_a && !flag_b) |=> (!flag_a && !flag_b));

endmodule

// File: tb/tb_pc_break_unit.sv
module tb_pc_break_unit;
  logic clk = 0, rst_n = 0;
  logic if_valid = 0, if_discard = 0, bus_cpu = 1;
  logic [23:0] if_addr = '0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic brk_irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pc_break_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic fetch(input logic [23:0] a, input logic disc);
    @(negedge clk); if_addr = a; if_valid = 1; if_discard = disc;
    @(negedge clk); if_valid = 0; if_discard = 0;
  endtask

  task automatic prog(input logic [3:0] base, input logic [23:0] t, input logic [23:0] m, input logic en);
    wr(base + 4'h0, t[7:0]); wr(base + 4'h1, t[15:8]); wr(base + 4'h2, t[23:16]);
    wr(base + 4'h4, m[7:0]); wr(base + 4'h5, m[15:8]); wr(base + 4'h6, m[23:16]);
    wr(base + 4'h3, {7'd0, en});
  endtask

  task automatic clear_flag(input logic [3:0] ca);
    logic [7:0] d;
    rd(ca, d); wr(ca, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'hF, d); chk("R1 stop bit", d, 8'h01);
    chk("R1 irq", brk_irq, 0);
    wr(4'hF, 8'h00);
    rd(4'h3, d); chk("R1 ctrl A", d, 8'h00);
    rd(4'hA, d); chk("R1 addr B hi", d, 8'h00);
  endtask

  task automatic t_stopped();
    logic [7:0] d;
    prog(4'h0, 24'h00ABCD, 24'h0, 1);
    wr(4'hF, 8'h01);
    wr(4'h4, 8'hFF);
    rd(4'h0, d); chk("R2 read while stopped", d, 8'h00);
    fetch(24'h00ABCD, 0);
    wr(4'hF, 8'h00);
    rd(4'h4, d); chk("R2 write ignored", d, 8'h00);
    rd(4'h3, d); chk("R2 no compare", d, 8'h01);
    chk("R2 irq", brk_irq, 0);
  endtask

  task automatic t_match();
    logic [7:0] d;
    prog(4'h0, 24'h123456, 24'h0000FF, 1);
    fetch(24'h124456, 0);
    rd(4'h3, d); chk("R3 near miss", d, 8'h01);
    fetch(24'h1234AB, 0);
    chk("R8 irq on A", brk_irq, 1);
    rd(4'hB, d); chk("R3 B untouched", d, 8'h00);
    rd(4'h3, d); chk("R3 flag A set", d, 8'h03);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    // state: flag A set and already read once above; write discards read
    wr(4'h3, 8'h03);
    wr(4'h3, 8'h01);
    rd(4'h3, d); chk("R7 zero write w/o fresh read", d, 8'h03);
    repeat (3) @(negedge clk);
    chk("R6 sticky irq", brk_irq, 1);
    rd(4'h3, d); wr(4'h3, 8'h01);
    rd(4'h3, d); chk("R7 read then clear", d, 8'h01);
    chk("R8 irq drops", brk_irq, 0);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    prog(4'h8, 24'h777777, 24'h0, 0);
    fetch(24'h777777, 0);
    rd(4'hB, d); chk("R4 disabled B", d, 8'h00);
    chk("R4 irq", brk_irq, 0);
  endtask

  task automatic t_discard();
    logic [7:0] d;
    fetch(24'h123456, 1);
    rd(4'h3, d); chk("R5 discarded fetch", d, 8'h01);
    chk("R5 irq", brk_irq, 0);
  endtask

  task automatic t_both();
    logic [7:0] d;
    prog(4'h8, 24'h123400, 24'h0000FF, 1);
    fetch(24'h123411, 0);
    rd(4'h3, d); chk("R8 both A", d, 8'h03);
    rd(4'hB, d); chk("R8 both B", d, 8'h03);
    clear_flag(4'h3);
    chk("R8 irq held by B", brk_irq, 1);
    clear_flag(4'hB);
    chk("R8 irq clear", brk_irq, 0);
  endtask

  task automatic t_bus();
    @(negedge clk); bus_cpu = 0;
    fetch(24'h123456, 0);
    @(negedge clk);
    chk("R9 held off", brk_irq, 0);
    bus_cpu = 1;
    #1 chk("R9 delivered", brk_irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_stopped();
    t_match();
    t_clear();
    t_enable();
    t_discard();
    t_both();
    t_bus();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule